// File: doc/BRIEF.md
# Int8 2x2 Matrix Multiply-Accumulate Tile

This block is a pipelined integer datapath. It multiplies a 2x8 matrix of 8-bit values by an 8x2 matrix of 8-bit values. The 2x2 product is added to a 2x2 tile of 32-bit accumulator lanes, and the four updated lanes are returned. The updated tile stands in place of the accumulator the caller supplied.

Each of the four result lanes is one 8-term dot product plus its accumulator lane. A 2-bit mode sets how the bytes are read: both operands signed, both unsigned, or the left operand unsigned and the right operand signed.

There is no handshake. A caller raises `inValid` with a complete operand set, and `outValid` marks the matching result a fixed number of cycles later. One operation can be issued every cycle. The first result register is always present. A second output register is present when `OUT_REG` is 1, which is the default.

Top module: `mmaTile`

## Requirements
- R1: Left-operand byte index `i*8+k` holds row i, column k. Right-operand bytes `j*8` to `j*8+7` hold column j, with row k at byte `j*8+k`. Result lane 0 (bits 31:0) is element (0,0), lane 1 is (0,1), lane 2 is (1,0) and lane 3 (bits 127:96) is (1,1).
- R2: Each result lane equals its accumulator lane plus the dot product of the matching left row and right column.
- R3: With mode 2'b00, both operands are read as two's-complement bytes.
- R4: With mode 2'b01, both operands are read as unsigned bytes.
- R5: With mode 2'b10, the left operand is read as unsigned and the right operand as two's complement. This holds over the full byte ranges.
- R6: Mode 2'b11 gives the same result as mode 2'b00.
- R7: Accumulation wraps modulo 2^32 with no saturation.
- R8: With the default `OUT_REG=1`, `outValid` is high exactly two cycles after `inValid`. Operations issued on consecutive cycles come out on consecutive cycles, each with its own result.
- R9: In a cycle where `outValid` is low, `result` keeps its previous value, whatever the operand inputs do.
- R10: During and directly after reset, `outValid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand set present this cycle |
| mode | input | 2 | Signedness: 00 signed, 01 unsigned, 10 left unsigned / right signed, 11 as 00 |
| srcA | input | 128 | Left 2x8 matrix, row-major bytes |
| srcB | input | 128 | Right 8x2 matrix, column-major bytes |
| accIn | input | 128 | Four 32-bit accumulator lanes |
| outValid | output | 1 | Result valid |
| result | output | 128 | Four updated 32-bit lanes |

## Verification
Two functions can fall in the same cycle. A new operation is captured into the first stage while the previous operation moves into the output stage. The bench provokes this by streaming its vector table one vector per cycle, with the mode changing between neighbours. Each result seen two cycles after its issue is compared against a model of that vector alone, so any mixing of stage contents or signedness between neighbours shows up as a mismatch.

// File: rtl/mmaPkg.sv
package mmaPkg;

  typedef enum logic [1:0] {
    MODE_SS  = 2'b00,
    MODE_UU  = 2'b01,
    MODE_US  = 2'b10,
    MODE_RSV = 2'b11
  } mmaMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic stage1En;
    logic stage2En;
    logic aSigned;
    logic bSigned;
  } mmaCtl_t;

endpackage

// File: rtl/mmaCtrl.sv
module mmaCtrl
  import mmaPkg::*;
#(
  parameter int OUT_REG = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [1:0]    mode,
  output mmaCtl_t       ctl,
  output logic          outValid
);

  logic s1Valid;
  mmaMode_e modeE;

  assign modeE = mmaMode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rstN) s1Valid <= 1'b0;
    else       s1Valid <= inValid;
  end

  always_comb begin
    ctl.stage1En = inValid;
    ctl.stage2En = s1Valid;
    unique case (modeE)
      MODE_UU: begin ctl.aSigned = 1'b0; ctl.bSigned = 1'b0; end
      MODE_US: begin ctl.aSigned = 1'b0; ctl.bSigned = 1'b1; end
      default: begin ctl.aSigned = 1'b1; ctl.bSigned = 1'b1; end // 00 and reserved 11
    endcase
  end

  generate
    if (OUT_REG != 0) begin : gOutStage
      logic s2Valid;
      always_ff @(posedge clk) begin
        if (!rstN) s2Valid <= 1'b0;
        else       s2Valid <= s1Valid;
      end
      assign outValid = s2Valid;
    end else begin : gNoOutStage
      assign outValid = s1Valid;
    end
  endgenerate

endmodule

// File: rtl/mmaDatapath.sv
module mmaDatapath
  import mmaPkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int ROWS    = 2,
  parameter int COLS    = 2,
  parameter int DEPTH   = 8,
  parameter int ACC_W   = 32,
  parameter int OUT_REG = 1,
  localparam int A_W    = ROWS * DEPTH * ELEM_W,
  localparam int B_W    = DEPTH * COLS * ELEM_W,
  localparam int LANES  = ROWS * COLS,
  localparam int R_W    = LANES * ACC_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  mmaCtl_t        ctl,
  input  logic [A_W-1:0] srcA,
  input  logic [B_W-1:0] srcB,
  input  logic [R_W-1:0] accIn,
  output logic [R_W-1:0] result
);

  localparam int EXT_W  = ELEM_W + 1;
  localparam int PROD_W = 2 * ELEM_W + 1;

  logic [R_W-1:0] stage1;

  generate
    for (genvar i = 0; i < ROWS; i++) begin : gRow
      for (genvar j = 0; j < COLS; j++) begin : gCol
        localparam int LANE = i * COLS + j;
        logic [ACC_W-1:0] laneSum;

        always_comb begin
          logic signed [EXT_W-1:0]  extA;
          logic signed [EXT_W-1:0]  extB;
          logic signed [PROD_W-1:0] prod;
          logic [ELEM_W-1:0]        byteA;
          logic [ELEM_W-1:0]        byteB;
          laneSum = accIn[LANE*ACC_W +: ACC_W];
          for (int k = 0; k < DEPTH; k++) begin
            byteA = srcA[(i*DEPTH + k)*ELEM_W +: ELEM_W];
            byteB = srcB[(j*DEPTH + k)*ELEM_W +: ELEM_W];
            extA  = {ctl.aSigned & byteA[ELEM_W-1], byteA};
            extB  = {ctl.bSigned & byteB[ELEM_W-1], byteB};
            prod  = PROD_W'(extA * extB);
            laneSum = laneSum + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
          end
        end

        always_ff @(posedge clk) begin
          if (!rstN)             stage1[LANE*ACC_W +: ACC_W] <= '0;
          else if (ctl.stage1En) stage1[LANE*ACC_W +: ACC_W] <= laneSum;
        end
      end
    end

    if (OUT_REG != 0) begin : gOutStage
      logic [R_W-1:0] stage2;
      always_ff @(posedge clk) begin
        if (!rstN)             stage2 <= '0;
        else if (ctl.stage2En) stage2 <= stage1;
      end
      assign result = stage2;
    end else begin : gNoOutStage
      assign result = stage1;
    end
  endgenerate

endmodule

// File: rtl/mmaTile.sv
module mmaTile
  import mmaPkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int ROWS    = 2,
  parameter int COLS    = 2,
  parameter int DEPTH   = 8,
  parameter int ACC_W   = 32,
  parameter int OUT_REG = 1,
  localparam int A_W    = ROWS * DEPTH * ELEM_W,
  localparam int B_W    = DEPTH * COLS * ELEM_W,
  localparam int R_W    = ROWS * COLS * ACC_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [1:0]     mode,
  input  logic [A_W-1:0] srcA,
  input  logic [B_W-1:0] srcB,
  input  logic [R_W-1:0] accIn,
  output logic           outValid,
  output logic [R_W-1:0] result
);

  mmaCtl_t ctl;

  mmaCtrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .mode     (mode),
    .ctl      (ctl),
    .outValid (outValid)
  );

  mmaDatapath #(
    .ELEM_W (ELEM_W),
    .ROWS   (ROWS),
    .COLS   (COLS),
    .DEPTH  (DEPTH),
    .ACC_W  (ACC_W),
    .OUT_REG(OUT_REG)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .srcA   (srcA),
    .srcB   (srcB),
    .accIn  (accIn),
    .result (result)
  );

endmodule

// File: rtl/mmaTileChk.sv
module mmaTileChk #(
  parameter int A_W     = 128,
  parameter int B_W     = 128,
  parameter int R_W     = 128,
  parameter int OUT_REG = 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic [A_W-1:0] srcA,
  input logic [B_W-1:0] srcB,
  input logic [R_W-1:0] accIn,
  input logic           outValid,
  input logic [R_W-1:0] result
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result)); // R9

  generate
    if (OUT_REG != 0) begin : gLat2
      AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
        $past(inValid, 2) |-> outValid); // R8
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> $past(inValid, 2)); // R8
      AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rstN)
        $past(inValid && (srcA == '0), 2) |-> result == $past(accIn, 2)); // R2
      AST_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
        $past(inValid && (srcB == '0), 2) |-> result == $past(accIn, 2)); // R2
    end else begin : gLat1
      AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
        $past(inValid) |-> outValid); // R8
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> $past(inValid)); // R8
      AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rstN)
        $past(inValid && (srcA == '0)) |-> result == $past(accIn)); // R2
      AST_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
        $past(inValid && (srcB == '0)) |-> result == $past(accIn)); // R2
    end
  endgenerate

endmodule

bind mmaTile mmaTileChk #(
  .A_W(A_W), .B_W(B_W), .R_W(R_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
  .accIn(accIn), .outValid(outValid), .result(result)
);

// File: tb/mmaTile_bench.sv
module mmaTile_bench;

  typedef struct packed {
    logic [1:0]   mode;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] acc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    // 0: signed, incrementing bytes
    '{2'b00, 128'h100F0E0D0C0B0A090807060504030201, 128'h0102030405060708F1F2F3F4F5F6F7F8, 128'h0},
    // 1: unsigned, all 0xFF
    '{2'b01, {16{8'hFF}}, {16{8'hFF}}, 128'h0},
    // 2: signed, all 0xFF
    '{2'b00, {16{8'hFF}}, {16{8'hFF}}, 128'h0},
    // 3: mixed, left 0xFF, right 0x80
    '{2'b10, {16{8'hFF}}, {16{8'h80}}, 128'h0},
    // 4: reserved mode, all 0xFF, nonzero accumulator
    '{2'b11, {16{8'hFF}}, {16{8'hFF}}, 128'h00000004_FFFFFFF0_00000100_00000010},
    // 5: unsigned, wrap past 2^32
    '{2'b01, {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFFFFF0}}},
    // 6: signed, -128*-128, wrap past max positive
    '{2'b00, {16{8'h80}}, {16{8'h80}}, {4{32'h7FFFFFFF}}},
    // 7: lane order, row0=1 row1=2, col0=1 col1=3
    '{2'b00, {{8{8'h02}}, {8{8'h01}}}, {{8{8'h03}}, {8{8'h01}}}, 128'h0},
    // 8: mixed, left 0x80 (128), right 0xFF (-1)
    '{2'b10, {16{8'h80}}, {16{8'hFF}}, 128'h0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic [127:0] accIn = '0;
  logic         outValid;
  logic [127:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  mmaTile u_mmaTile (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] model(logic [1:0] m, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] acc);
    logic [127:0] r;
    bit sa;
    bit sb;
    sa = (m == 2'b00) || (m == 2'b11);
    sb = (m != 2'b01);
    r  = '0;
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        int s;
        s = int'(acc[(i*2+j)*32 +: 32]);
        for (int k = 0; k < 8; k++) begin
          int x;
          int y;
          x = sa ? int'($signed(a[(i*8+k)*8 +: 8])) : int'(a[(i*8+k)*8 +: 8]);
          y = sb ? int'($signed(b[(j*8+k)*8 +: 8])) : int'(b[(j*8+k)*8 +: 8]);
          s = s + x * y;
        end
        r[(i*2+j)*32 +: 32] = s;
      end
    end
    return r;
  endfunction

  function automatic string tagOf(int n);
    case (n)
      1, 5:    return "R4/R7";
      3, 8:    return "R5";
      4:       return "R6";
      6:       return "R3/R7";
      7:       return "R1";
      default: return "R3/R2";
    endcase
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, int n);
    inValid = v;
    mode    = VEC[n].mode;
    srcA    = VEC[n].a;
    srcB    = VEC[n].b;
    accIn   = VEC[n].acc;
  endtask

  initial begin
    // R10: outputs during reset
    repeat (3) @(negedge clk);
    chk("R10 outValid in reset", {127'b0, outValid}, 128'h0);
    chk("R10 result in reset", result, 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 outValid after reset", {127'b0, outValid}, 128'h0);
    chk("R10 result after reset", result, 128'h0);

    // table stream, one vector per cycle (R8 back-to-back)
    for (int c = 0; c < NV + 2; c++) begin
      if (c == 1) chk("R8 not early", {127'b0, outValid}, 128'h0);
      if (c >= 2) begin
        chk("R8 outValid stream", {127'b0, outValid}, 128'h1);
        chk(tagOf(c - 2), result,
            model(VEC[c-2].mode, VEC[c-2].a, VEC[c-2].b, VEC[c-2].acc));
      end
      if (c < NV) drive(1'b1, c);
      else        inValid = 1'b0;
      @(negedge clk);
    end

    // R9: idle with moving inputs, result held
    begin
      logic [127:0] last;
      last = model(VEC[NV-1].mode, VEC[NV-1].a, VEC[NV-1].b, VEC[NV-1].acc);
      for (int c = 0; c < 3; c++) begin
        drive(1'b0, c);
        @(negedge clk);
        chk("R9 outValid idle", {127'b0, outValid}, 128'h0);
        chk("R9 result held", result, last);
      end
    end

    // R8: single issue, exact latency, then drop
    drive(1'b1, 7);
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 latency cycle 1", {127'b0, outValid}, 128'h0);
    @(negedge clk);
    chk("R8 latency cycle 2", {127'b0, outValid}, 128'h1);
    chk("R1 lane order", result, 128'h00000030_00000010_00000018_00000008);
    @(negedge clk);
    chk("R8 single pulse", {127'b0, outValid}, 128'h0);
    chk("R9 held after pulse", result, 128'h00000030_00000010_00000018_00000008);

    // R6: reserved mode matches signed on same operands
    drive(1'b1, 4);
    mode = 2'b11;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk("R6 reserved as signed", result,
        model(2'b00, VEC[4].a, VEC[4].b, VEC[4].acc));

    // R10: reset mid-flight clears outputs
    drive(1'b1, 1);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    chk("R10 outValid mid reset", {127'b0, outValid}, 128'h0);
    chk("R10 result mid reset", result, 128'h0);
    rstN = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule